// File: doc/BRIEF.md
# Double-Buffered Photon-Counting Pixel Counter Array

This block holds one event counter per pixel of a small detector tile. A comparator delivers a single-cycle hit pulse for each photon above threshold. During an exposure frame every pixel accumulates its hits as a plain binary count. A one-cycle frame-boundary strobe copies each live count, with its overflow flag, into a per-pixel storage register. In the same cycle it clears the live counters. The next frame therefore starts counting at once, while the stored frame is read out.

The counting depth can be set to 4, 8 or 12 bits. A new depth setting is taken only at a frame boundary, so it never changes partway through a frame. A global control chooses what a full counter does: it either holds at its all-ones value and sets a sticky flag, or rolls over to zero. Readout is random access. The requester gives a row and a column, and one cycle later the block returns the stored count, zero-extended to 12 bits, together with that pixel's overflow flag.

Top module: `pxc_top`

## Requirements
- R1: After reset every live and stored count is 0, every overflow flag is 0, `rd_valid` is 0 and the active depth is 12 bits.
- R2: Each cycle with a pixel's `hit` bit high and `frame_end` low adds one to that pixel's live count. `frame_end` copies the live count into the stored count, which readout then returns.
- R3: With `ovf_en` high, a hit on a counter at the all-ones value of the active depth leaves the count unchanged and sets the pixel's overflow flag. The flag stays set until the next `frame_end` copies it to storage.
- R4: With `ovf_en` low, a hit on a counter at its all-ones value wraps the count to 0, and the overflow flag is not set.
- R5: In a `frame_end` cycle the live count restarts at 1 if the pixel's hit bit is high, and at 0 otherwise. The live overflow flag restarts at 0.
- R6: A stored count and its flag change only in a `frame_end` cycle. Readout during counting returns the previous frame.
- R7: `depth_req` is sampled into the active depth only in a `frame_end` cycle, and the new depth applies to the frame that starts there. Encoding: 00 = 4 bits, 01 = 8 bits, 10 and 11 = 12 bits.
- R8: `rd_valid` is high exactly in the cycle after a cycle with `rd_req` high. In that cycle `rd_data` holds the stored count of pixel `rd_row*COLS+rd_col`, zero-extended to 12 bits, and `rd_ovf` holds that pixel's stored flag.
- R9: Pixels count independently. Hits on one pixel do not change any other pixel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hit | input | ROWS*COLS (16) | Per-pixel hit pulses; bit index is row*COLS+col |
| frame_end | input | 1 | Frame boundary strobe |
| ovf_en | input | 1 | 1 = saturate and flag, 0 = wrap |
| depth_req | input | 2 | Requested counter depth |
| rd_req | input | 1 | Read request |
| rd_row | input | $clog2(ROWS) (2) | Row address |
| rd_col | input | $clog2(COLS) (2) | Column address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 12 | Stored count, zero-extended |
| rd_ovf | output | 1 | Stored overflow flag |

## Verification
The checker watches pixel 0 on every cycle. It checks that the live count stays within the active depth, that a full counter saturates or wraps as `ovf_en` selects, and that the flag stays set until the frame boundary. It also checks that each frame boundary restarts the live count at 0 or 1, that stored values hold between boundaries, and that the read latency is exactly one cycle. Some behaviour can only be shown by the bench's scenarios against its reference model. This covers a depth request that must wait for the boundary, readout of an earlier frame while a later one counts, the mapping from row and column to pixel, and the independence of the other pixels.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  localparam int unsigned CNT_W = 12;

  typedef enum logic [1:0] {
    DEPTH4   = 2'b00,
    DEPTH8   = 2'b01,
    DEPTH12  = 2'b10,
    DEPTH12B = 2'b11
  } depth_e;

  function automatic logic [CNT_W-1:0] depth_max(input depth_e d);
    case (d)
      DEPTH4:  depth_max = CNT_W'(12'h00F);
      DEPTH8:  depth_max = CNT_W'(12'h0FF);
      default: depth_max = CNT_W'(12'hFFF);
    endcase
  endfunction
endpackage

// File: rtl/pxc_depth_ctl.sv
module pxc_depth_ctl
  import pxc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic [1:0]       depth_req,
  output depth_e           depth_q,
  output logic [CNT_W-1:0] cnt_max
);
  depth_e depth_d;

  always_comb begin
    depth_d = depth_q;
    if (frame_end) depth_d = depth_e'(depth_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_q <= DEPTH12;
    else if (frame_end) depth_q <= depth_d;
  end

  assign cnt_max = depth_max(depth_q);
endmodule

// File: rtl/pxc_cell.sv
module pxc_cell
  import pxc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             frame_end,
  input  logic             ovf_en,
  input  logic [CNT_W-1:0] cnt_max,
  output logic [CNT_W-1:0] live_cnt,
  output logic             live_ovf,
  output logic [CNT_W-1:0] buf_cnt,
  output logic             buf_ovf
);
  logic [CNT_W-1:0] live_d;
  logic             ovf_d;
  logic             live_en;
  logic             at_top;

  assign at_top  = (live_cnt == cnt_max);
  assign live_en = hit | frame_end;

  always_comb begin
    live_d = live_cnt;
    ovf_d  = live_ovf;
    if (frame_end) begin
      live_d = hit ? CNT_W'(1) : '0;
      ovf_d  = 1'b0;
    end else if (hit) begin
      if (!at_top) begin
        live_d = live_cnt + CNT_W'(1);
      end else if (ovf_en) begin
        ovf_d = 1'b1;
      end else begin
        live_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_cnt <= '0;
      live_ovf <= 1'b0;
    end else if (live_en) begin
      live_cnt <= live_d;
      live_ovf <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_cnt <= '0;
      buf_ovf <= 1'b0;
    end else if (frame_end) begin
      buf_cnt <= live_cnt;
      buf_ovf <= live_ovf;
    end
  end
endmodule

// File: rtl/pxc_readout.sv
module pxc_readout
  import pxc_pkg::*;
#(
  parameter int unsigned NPIX = 16,
  localparam int unsigned IW  = $clog2(NPIX)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_req,
  input  logic [IW-1:0]              rd_idx,
  input  logic [NPIX-1:0][CNT_W-1:0] buf_cnt,
  input  logic [NPIX-1:0]            buf_ovf,
  output logic                       rd_valid,
  output logic [CNT_W-1:0]           rd_data,
  output logic                       rd_ovf
);
  logic [CNT_W-1:0] data_d;
  logic             ovf_d;

  always_comb begin
    data_d = buf_cnt[rd_idx];
    ovf_d  = buf_ovf[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_ovf  <= 1'b0;
    end else if (rd_req) begin
      rd_data <= data_d;
      rd_ovf  <= ovf_d;
    end
  end
endmodule

// File: rtl/pxc_top.sv
module pxc_top
  import pxc_pkg::*;
#(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 4,
  localparam int unsigned NPIX = ROWS * COLS,
  localparam int unsigned RW   = $clog2(ROWS),
  localparam int unsigned CWA  = $clog2(COLS),
  localparam int unsigned IW   = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIX-1:0]  hit,
  input  logic             frame_end,
  input  logic             ovf_en,
  input  logic [1:0]       depth_req,
  input  logic             rd_req,
  input  logic [RW-1:0]    rd_row,
  input  logic [CWA-1:0]   rd_col,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_ovf
);
  logic                       rst_meta_n;
  logic                       rst_sync_n;
  depth_e                     depth_q;
  logic [CNT_W-1:0]           cnt_max;
  logic [NPIX-1:0][CNT_W-1:0] live_cnt;
  logic [NPIX-1:0]            live_ovf;
  logic [NPIX-1:0][CNT_W-1:0] buf_cnt;
  logic [NPIX-1:0]            buf_ovf;
  logic [IW-1:0]              rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  pxc_depth_ctl u_depth (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .frame_end (frame_end),
    .depth_req (depth_req),
    .depth_q   (depth_q),
    .cnt_max   (cnt_max)
  );

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    pxc_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .hit       (hit[p]),
      .frame_end (frame_end),
      .ovf_en    (ovf_en),
      .cnt_max   (cnt_max),
      .live_cnt  (live_cnt[p]),
      .live_ovf  (live_ovf[p]),
      .buf_cnt   (buf_cnt[p]),
      .buf_ovf   (buf_ovf[p])
    );
  end

  assign rd_idx = IW'(rd_row) * IW'(COLS) + IW'(rd_col);

  pxc_readout #(.NPIX(NPIX)) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_req   (rd_req),
    .rd_idx   (rd_idx),
    .buf_cnt  (buf_cnt),
    .buf_ovf  (buf_ovf),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_ovf   (rd_ovf)
  );
endmodule

// File: rtl/pxc_checker.sv
module pxc_checker
  import pxc_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input logic             hit0,
  input logic             frame_end,
  input logic             ovf_en,
  input logic             rd_req,
  input logic             rd_valid,
  input depth_e           depth_q,
  input logic [CNT_W-1:0] live0,
  input logic             ovf0,
  input logic [CNT_W-1:0] buf0,
  input logic             bovf0
);
  logic [CNT_W-1:0] top_now;
  assign top_now = depth_max(depth_q);

  AST_RD_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_req |=> rd_valid); // R8
  AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_req |=> !rd_valid); // R8
  AST_IN_DEPTH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    live0 <= top_now); // R7
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_en && hit0 && !frame_end && live0 == top_now) |=> (live0 == $past(live0) && ovf0)); // R3
  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf0 && !frame_end) |=> ovf0); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ovf_en && hit0 && !frame_end && live0 == top_now) |=> (live0 == '0 && ovf0 == $past(ovf0))); // R4
  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_end |=> (live0 == ($past(hit0) ? CNT_W'(1) : CNT_W'(0)) && !ovf0)); // R5
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !frame_end |=> ($stable(buf0) && $stable(bovf0))); // R6
endmodule

bind pxc_top pxc_checker u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .hit0       (hit[0]),
  .frame_end  (frame_end),
  .ovf_en     (ovf_en),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .depth_q    (depth_q),
  .live0      (live_cnt[0]),
  .ovf0       (live_ovf[0]),
  .buf0       (buf_cnt[0]),
  .bovf0      (buf_ovf[0])
);

// File: tb/pxc_top_bench.sv
`timescale 1ns/1ps
module pxc_top_bench;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int NPIX = ROWS * COLS;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NPIX-1:0] hit;
  logic            frame_end;
  logic            ovf_en;
  logic [1:0]      depth_req;
  logic            rd_req;
  logic [1:0]      rd_row;
  logic [1:0]      rd_col;
  logic            rd_valid;
  logic [11:0]     rd_data;
  logic            rd_ovf;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pxc_top #(.ROWS(ROWS), .COLS(COLS)) u_pxc_top (
    .clk(clk), .rst_n(rst_n), .hit(hit), .frame_end(frame_end),
    .ovf_en(ovf_en), .depth_req(depth_req), .rd_req(rd_req),
    .rd_row(rd_row), .rd_col(rd_col), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ovf(rd_ovf)
  );

  // behavioural reference model
  int m_depth;
  int m_live[NPIX];
  int m_lovf[NPIX];
  int m_buf[NPIX];
  int m_bovf[NPIX];
  int m_rv, m_rd, m_ro;

  function automatic int top_of(input int d);
    if (d == 0) return 15;
    if (d == 1) return 255;
    return 4095;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_depth = 2;
      m_rv = 0; m_rd = 0; m_ro = 0;
      for (int i = 0; i < NPIX; i++) begin
        m_live[i] = 0; m_lovf[i] = 0; m_buf[i] = 0; m_bovf[i] = 0;
      end
    end else begin
      m_rv = rd_req;
      if (rd_req) begin
        m_rd = m_buf[rd_row * COLS + rd_col];
        m_ro = m_bovf[rd_row * COLS + rd_col];
      end
      for (int i = 0; i < NPIX; i++) begin
        if (frame_end) begin
          m_buf[i] = m_live[i];
          m_bovf[i] = m_lovf[i];
          m_live[i] = hit[i] ? 1 : 0;
          m_lovf[i] = 0;
        end else if (hit[i]) begin
          if (m_live[i] < top_of(m_depth)) m_live[i] = m_live[i] + 1;
          else if (ovf_en) m_lovf[i] = 1;
          else m_live[i] = 0;
        end
      end
      if (frame_end) m_depth = depth_req;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R8 rd_valid vs model", int'(rd_valid), m_rv);
      if (m_rv != 0) begin
        check("R2 rd_data vs model", int'(rd_data), m_rd);
        check("R3 rd_ovf vs model", int'(rd_ovf), m_ro);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic pulses(input logic [NPIX-1:0] mask, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); hit = mask;
    end
    @(negedge clk); hit = '0;
  endtask

  task automatic boundary(input logic [NPIX-1:0] mask);
    @(negedge clk); frame_end = 1'b1; hit = mask;
    @(negedge clk); frame_end = 1'b0; hit = '0;
  endtask

  task automatic rd(input int r, input int c, input int exp, input int eo, input string tag);
    @(negedge clk); rd_req = 1'b1; rd_row = 2'(r); rd_col = 2'(c);
    @(negedge clk); rd_req = 1'b0;
    check({tag, " valid"}, int'(rd_valid), 1);
    check({tag, " data"}, int'(rd_data), exp);
    check({tag, " ovf"}, int'(rd_ovf), eo);
  endtask

  initial begin
    rst_n = 1'b0; hit = '0; frame_end = 1'b0; ovf_en = 1'b1;
    depth_req = 2'b10; rd_req = 1'b0; rd_row = '0; rd_col = '0;
    repeat (3) @(negedge clk);
    check("R1 rd_valid in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rd_valid after reset", int'(rd_valid), 0);
    rd(0, 0, 0, 0, "R1 stored count zero");

    // frame A: 12-bit, mode request for 4-bit waits for boundary
    pulses(16'h0001, 5);
    pulses(16'h0020, 3);
    pulses(16'hFFFF, 2);
    depth_req = 2'b00;
    pulses(16'h0008, 20);
    boundary('0);
    rd(0, 0, 7, 0, "R2 pixel0 count");
    rd(1, 1, 5, 0, "R9 pixel5 independent");
    rd(0, 3, 22, 0, "R7 depth deferred to boundary");
    rd(0, 1, 2, 0, "R9 pixel1 broadcast");

    // frame B: 4-bit saturate; readout of previous frame during counting
    pulses(16'h0001, 20);
    rd(0, 3, 22, 0, "R6 previous frame held");
    boundary(16'h0004);
    rd(0, 0, 15, 1, "R3 saturate and flag");
    rd(0, 2, 0, 0, "R5 old frame of pixel2");

    // frame C: 4-bit wrap; boundary hit counted into new frame
    ovf_en = 1'b0;
    depth_req = 2'b01;
    pulses(16'h0004, 3);
    pulses(16'h0002, 20);
    pulses(16'h0001, 16);
    boundary('0);
    rd(0, 2, 4, 0, "R5 boundary hit counted");
    rd(0, 1, 4, 0, "R4 wrap modulo 16");
    rd(0, 0, 0, 0, "R4 wrap to zero no flag");

    // frame D: 8-bit saturate
    ovf_en = 1'b1;
    pulses(16'h8000, 300);
    boundary('0);
    rd(3, 3, 255, 1, "R7 8-bit depth top");
    rd(0, 0, 0, 0, "R5 flag cleared next frame");

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule